// File: doc/BRIEF.md
# Branch Record Unpacker and Compactor

This block receives raw branch records one per handshake, newest first, and turns each one into a clean entry. A record holds a 64-bit source word, a 64-bit target word, an optional 64-bit info word and a branch-type tag computed upstream. The selected record layout decides where the flag fields live. The flag bits packed into the upper bits of an address word are removed, and the address is rebuilt by sign extension. The block also yields the mispredict, predicted, in-transaction, abort and cycle-count fields.

Each unpacked entry goes into an internal buffer together with a keep bit, which is computed from the tag and a requested type mask. When duplicate-abort mode is on, a record carrying the abort flag replaces the entry written just before it. Entries are released only after the record marked last has been accepted, so a late overwrite can still land. During release, entries whose keep bit is clear are skipped. The survivors leave as a valid/ready stream in their original order, and a one-cycle done pulse then presents the number of entries sent.

Top module: `br_rec_compactor`

## Requirements
- R1: After reset, `rec_ready_o` is 1, `ent_valid_o` is 0, `done_o` is 0 and `cnt_o` is 0.
- R2: Layout code 0: the output source is the record source word bits 31:0 and the output target is its bits 63:32, both zero-extended to 64 bits. Mispredict, predicted, in-transaction, abort and cycles are all 0.
- R3: Layout codes 3 and 6: mispredict is source bit 63, and the output source is bits 62:0 sign-extended from bit 62. For codes 3 to 6, predicted is always the inverse of mispredict.
- R4: Layout code 4: mispredict is source bit 63, in-transaction is bit 62 and abort is bit 61. The output source is bits 60:0 sign-extended from bit 60.
- R5: Layout code 5: mispredict is info bit 63, in-transaction is info bit 62, abort is info bit 61 and cycles is info bits 15:0. Source and target pass through unchanged.
- R6: Layout code 6: cycles is target bits 63:48, and the output target is bits 47:0 sign-extended from bit 47.
- R7: Layout codes 1, 2 and 7: source and target pass through unchanged, and all flag and cycle outputs are 0.
- R8: When `dup_abort_en_i` is 1, the record has abort set, and at least one entry is already stored in the batch, the record replaces the most recently stored entry, including its keep bit. Otherwise it is appended.
- R9: A record is dropped when its tag is zero or when (mask AND tag) differs from tag. Tag bit 0 is user, bit 2 is call, bit 3 is return and bit 8 is conditional.
- R10: When the mask has every bit of 18'h29FFF set, every record is kept, including one with a zero tag.
- R11: When the mask has bit 13 or bit 14 set and the tag is nonzero, bit 13 (in-transaction) is ORed into the tag if the entry's in-transaction flag is 1, and bit 14 (not in-transaction) is ORed in otherwise. Matching happens after this.
- R12: While records are being accepted, no entry is presented. After the last record, the kept entries leave in arrival order. A one-cycle `done_o` pulse follows, and at that pulse `cnt_o` equals the number of entries sent. `cnt_o` holds that value until the next pulse.
- R13: At most DEPTH entries are stored per batch. A non-overwriting record that arrives when the buffer is full is discarded, but its last marker still ends the batch.
- R14: While `ent_valid_o` is 1 and `ent_ready_i` is 0, the presented entry stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 3 | Record layout code, held for the whole batch |
| dup_abort_en_i | input | 1 | Enable duplicate-abort replacement |
| type_mask_i | input | 18 | Requested branch-type mask |
| rec_valid_i | input | 1 | Record valid |
| rec_ready_o | output | 1 | Record accepted when high |
| rec_last_i | input | 1 | Record is the last of the batch |
| rec_src_i | input | 64 | Raw source word |
| rec_dst_i | input | 64 | Raw target word |
| rec_info_i | input | 64 | Raw info word |
| rec_tag_i | input | 18 | Branch-type tag of the record |
| ent_valid_o | output | 1 | Entry valid |
| ent_ready_i | input | 1 | Downstream ready |
| ent_src_o | output | 64 | Clean source address |
| ent_dst_o | output | 64 | Clean target address |
| ent_mispred_o | output | 1 | Mispredicted |
| ent_pred_o | output | 1 | Predicted |
| ent_in_tx_o | output | 1 | Inside a transaction |
| ent_abort_o | output | 1 | Transaction abort |
| ent_cycles_o | output | 16 | Cycle count |
| cnt_o | output | $clog2(DEPTH+1) | Number of entries sent in the last batch |
| done_o | output | 1 | One-cycle end-of-batch pulse |

## Verification
Each record is registered at the clock edge where it is accepted. The first stored slot is presented in the cycle after the last record is accepted. Each stored slot then takes one cycle, or longer under backpressure, and a dropped slot takes one cycle with `ent_valid_o` low. `done_o` and the final `cnt_o` appear in the cycle after the final slot is consumed. The bench drives inputs and samples outputs on the falling edge, so it captures an entry exactly where valid and its own ready coincide, and it reads the count on the cycle where `done_o` is high. It does not assume a fixed latency. After each non-final record, it checks one cycle later that no entry is presented.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;
  localparam int CYC_W  = 16;
  localparam int TAG_W  = 18;

  localparam int TAG_IN_TX_BIT = 13;
  localparam int TAG_NO_TX_BIT = 14;
  localparam int TAG_CSTK_BIT  = 16;

  localparam logic [TAG_W-1:0] TAG_IN_TX_M = TAG_W'(1) << TAG_IN_TX_BIT;
  localparam logic [TAG_W-1:0] TAG_NO_TX_M = TAG_W'(1) << TAG_NO_TX_BIT;
  localparam logic [TAG_W-1:0] TAG_TX_M    = TAG_IN_TX_M | TAG_NO_TX_M;
  localparam logic [TAG_W-1:0] TAG_ALL_M   = ~(TAG_TX_M | (TAG_W'(1) << TAG_CSTK_BIT));

  typedef enum logic [2:0] {
    FMT_PACK32 = 3'd0,
    FMT_LIN    = 3'd1,
    FMT_EFF    = 3'd2,
    FMT_MIS    = 3'd3,
    FMT_MIS_TX = 3'd4,
    FMT_INFO   = 3'd5,
    FMT_TIMED  = 3'd6,
    FMT_RSVD   = 3'd7
  } fmt_e;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic              mis;
    logic              pred;
    logic              in_tx;
    logic              abort;
    logic [CYC_W-1:0]  cyc;
  } ent_t;
endpackage

// File: rtl/brc_unpack.sv
module brc_unpack
  import brc_pkg::*;
(
  input  fmt_e              fmt_i,
  input  logic [WORD_W-1:0] src_i,
  input  logic [WORD_W-1:0] dst_i,
  input  logic [WORD_W-1:0] info_i,
  output ent_t              ent_o
);
  localparam int MSB   = WORD_W - 1;
  localparam int DA_HI = WORD_W - CYC_W - 1;

  logic unused_info;
  assign unused_info = ^info_i[MSB-3:CYC_W];

  always_comb begin
    ent_o     = '0;
    ent_o.src = src_i;
    ent_o.dst = dst_i;
    unique case (fmt_i)
      FMT_PACK32: begin
        ent_o.src = {{HALF_W{1'b0}}, src_i[HALF_W-1:0]};
        ent_o.dst = {{HALF_W{1'b0}}, src_i[MSB:HALF_W]};
      end
      FMT_MIS: begin
        ent_o.mis  = src_i[MSB];
        ent_o.pred = ~src_i[MSB];
        ent_o.src  = {src_i[MSB-1], src_i[MSB-1:0]};
      end
      FMT_MIS_TX: begin
        ent_o.mis   = src_i[MSB];
        ent_o.pred  = ~src_i[MSB];
        ent_o.in_tx = src_i[MSB-1];
        ent_o.abort = src_i[MSB-2];
        ent_o.src   = {{3{src_i[MSB-3]}}, src_i[MSB-3:0]};
      end
      FMT_INFO: begin
        ent_o.mis   = info_i[MSB];
        ent_o.pred  = ~info_i[MSB];
        ent_o.in_tx = info_i[MSB-1];
        ent_o.abort = info_i[MSB-2];
        ent_o.cyc   = info_i[CYC_W-1:0];
      end
      FMT_TIMED: begin
        ent_o.mis  = src_i[MSB];
        ent_o.pred = ~src_i[MSB];
        ent_o.src  = {src_i[MSB-1], src_i[MSB-1:0]};
        ent_o.cyc  = dst_i[MSB:DA_HI+1];
        ent_o.dst  = {{CYC_W{dst_i[DA_HI]}}, dst_i[DA_HI:0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/brc_tag_filter.sv
module brc_tag_filter
  import brc_pkg::*;
(
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] mask_i,
  input  logic             in_tx_i,
  output logic             keep_o
);
  logic             bypass, tx_req;
  logic [TAG_W-1:0] tag_x;

  assign bypass = (mask_i & TAG_ALL_M) == TAG_ALL_M;
  assign tx_req = |(mask_i & TAG_TX_M);

  always_comb begin
    tag_x = tag_i;
    if (tx_req && tag_i != '0) tag_x = tag_i | (in_tx_i ? TAG_IN_TX_M : TAG_NO_TX_M);
  end

  assign keep_o = bypass || ((tag_x != '0) && ((mask_i & tag_x) == tag_x));
endmodule

// File: rtl/brc_slot_store.sv
module brc_slot_store
  import brc_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  ent_t             wdata_i,
  input  logic             wkeep_i,
  input  logic [IDX_W-1:0] raddr_i,
  output ent_t             rdata_o,
  output logic [DEPTH-1:0] keep_vec_o
);
  ent_t             mem_q [DEPTH];
  logic [DEPTH-1:0] keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) keep_q <= '0;
    else if (we_i) keep_q[waddr_i] <= wkeep_i;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o    = mem_q[raddr_i];
  assign keep_vec_o = keep_q;
endmodule

// File: rtl/br_rec_compactor.sv
module br_rec_compactor
  import brc_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        fmt_i,
  input  logic              dup_abort_en_i,
  input  logic [TAG_W-1:0]  type_mask_i,
  input  logic              rec_valid_i,
  output logic              rec_ready_o,
  input  logic              rec_last_i,
  input  logic [WORD_W-1:0] rec_src_i,
  input  logic [WORD_W-1:0] rec_dst_i,
  input  logic [WORD_W-1:0] rec_info_i,
  input  logic [TAG_W-1:0]  rec_tag_i,
  output logic              ent_valid_o,
  input  logic              ent_ready_i,
  output logic [WORD_W-1:0] ent_src_o,
  output logic [WORD_W-1:0] ent_dst_o,
  output logic              ent_mispred_o,
  output logic              ent_pred_o,
  output logic              ent_in_tx_o,
  output logic              ent_abort_o,
  output logic [CYC_W-1:0]  ent_cycles_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  typedef enum logic {ST_FILL, ST_DRAIN} st_e;

  st_e              st_q;
  logic [CNT_W-1:0] wr_cnt_q, kept_q, rd_q, cnt_q;
  logic             done_q;

  ent_t             rec_ent, rd_ent;
  logic             rec_keep, old_keep, rd_keep;
  logic [DEPTH-1:0] keep_vec;
  logic             accept, ovr, do_wr, rd_end, rd_adv;
  logic [IDX_W-1:0] wr_idx, prev_idx;

  brc_unpack u_unpack (
    .fmt_i (fmt_e'(fmt_i)),
    .src_i (rec_src_i),
    .dst_i (rec_dst_i),
    .info_i(rec_info_i),
    .ent_o (rec_ent)
  );

  brc_tag_filter u_filter (
    .tag_i  (rec_tag_i),
    .mask_i (type_mask_i),
    .in_tx_i(rec_ent.in_tx),
    .keep_o (rec_keep)
  );

  brc_slot_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (do_wr),
    .waddr_i   (wr_idx),
    .wdata_i   (rec_ent),
    .wkeep_i   (rec_keep),
    .raddr_i   (rd_q[IDX_W-1:0]),
    .rdata_o   (rd_ent),
    .keep_vec_o(keep_vec)
  );

  assign rec_ready_o = (st_q == ST_FILL);
  assign accept      = rec_valid_i & rec_ready_o;
  assign prev_idx    = IDX_W'(wr_cnt_q - 1'b1);
  // abort record folds onto the entry written just before it
  assign ovr         = dup_abort_en_i & rec_ent.abort & (wr_cnt_q != '0);
  assign do_wr       = accept & (ovr | (wr_cnt_q < CNT_W'(DEPTH)));
  assign wr_idx      = ovr ? prev_idx : IDX_W'(wr_cnt_q);
  assign old_keep    = keep_vec[prev_idx];

  assign rd_end      = (rd_q == wr_cnt_q);
  assign rd_keep     = keep_vec[rd_q[IDX_W-1:0]];
  assign ent_valid_o = (st_q == ST_DRAIN) & ~rd_end & rd_keep;
  assign rd_adv      = (st_q == ST_DRAIN) & ~rd_end & (~rd_keep | ent_ready_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_FILL;
      wr_cnt_q <= '0;
      kept_q   <= '0;
      rd_q     <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_FILL: begin
          if (do_wr) begin
            if (ovr) begin
              kept_q <= kept_q - CNT_W'(old_keep) + CNT_W'(rec_keep);
            end else begin
              kept_q   <= kept_q + CNT_W'(rec_keep);
              wr_cnt_q <= wr_cnt_q + 1'b1;
            end
          end
          if (accept && rec_last_i) begin
            st_q <= ST_DRAIN;
            rd_q <= '0;
          end
        end
        ST_DRAIN: begin
          if (rd_end) begin
            st_q     <= ST_FILL;
            done_q   <= 1'b1;
            cnt_q    <= kept_q;
            wr_cnt_q <= '0;
            kept_q   <= '0;
          end else if (rd_adv) begin
            rd_q <= rd_q + 1'b1;
          end
        end
        default: st_q <= ST_FILL;
      endcase
    end
  end

  assign ent_src_o     = rd_ent.src;
  assign ent_dst_o     = rd_ent.dst;
  assign ent_mispred_o = rd_ent.mis;
  assign ent_pred_o    = rd_ent.pred;
  assign ent_in_tx_o   = rd_ent.in_tx;
  assign ent_abort_o   = rd_ent.abort;
  assign ent_cycles_o  = rd_ent.cyc;
  assign cnt_o         = cnt_q;
  assign done_o        = done_q;
endmodule

// File: rtl/br_rec_compactor_chk.sv
module br_rec_compactor_chk
  import brc_pkg::*;
#(
  parameter  int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        fmt_i,
  input logic              rec_ready_o,
  input logic              ent_valid_o,
  input logic              ent_ready_i,
  input logic [WORD_W-1:0] ent_src_o,
  input logic [WORD_W-1:0] ent_dst_o,
  input logic              ent_mispred_o,
  input logic              ent_pred_o,
  input logic [CYC_W-1:0]  ent_cycles_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              done_o
);
  logic [CNT_W-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (done_o) seen_q <= '0;
    else if (ent_valid_o && ent_ready_i) seen_q <= seen_q + 1'b1;
  end

  assert_hold_R14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && !ent_ready_i |=> ent_valid_o && $stable(ent_src_o) && $stable(ent_dst_o)
                                    && $stable(ent_cycles_o))
    else $error("entry changed under backpressure");

  assert_fill_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_ready_o |-> !ent_valid_o)
    else $error("entry presented while filling");

  assert_count_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o == seen_q)
    else $error("final count differs from entries sent");

  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  assert_cap_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cnt_o <= CNT_W'(DEPTH))
    else $error("count above depth");

  assert_pred_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && fmt_i >= 3'd3 && fmt_i <= 3'd6 |-> ent_pred_o != ent_mispred_o)
    else $error("predicted not inverse of mispredict");

  assert_pack32_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && fmt_i == 3'd0 |-> !ent_mispred_o && !ent_pred_o
                                      && ent_src_o[WORD_W-1:HALF_W] == '0
                                      && ent_dst_o[WORD_W-1:HALF_W] == '0)
    else $error("packed layout flags or upper halves nonzero");
endmodule

bind br_rec_compactor br_rec_compactor_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fmt_i        (fmt_i),
  .rec_ready_o  (rec_ready_o),
  .ent_valid_o  (ent_valid_o),
  .ent_ready_i  (ent_ready_i),
  .ent_src_o    (ent_src_o),
  .ent_dst_o    (ent_dst_o),
  .ent_mispred_o(ent_mispred_o),
  .ent_pred_o   (ent_pred_o),
  .ent_cycles_o (ent_cycles_o),
  .cnt_o        (cnt_o),
  .done_o       (done_o)
);

// File: tb/tb_br_rec_compactor.sv
`timescale 1ns/1ps
module tb_br_rec_compactor;
  import brc_pkg::*;

  localparam int DEPTH = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [TAG_W-1:0] M_ALL = 18'h29FFF;
  localparam logic [TAG_W-1:0] T_UJ  = 18'h00101;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [63:0] src, dst, info, esrc, edst;
    logic        emis, epred, etx, eab;
    logic [15:0] ecyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{3'd0, 64'h1234_5678_9ABC_DEF0, 64'h0, 64'h0,
      64'h0000_0000_9ABC_DEF0, 64'h0000_0000_1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    '{3'd3, 64'h8000_0000_0040_1000, 64'hFFFF_8000_0000_2000, 64'h0,
      64'h0000_0000_0040_1000, 64'hFFFF_8000_0000_2000, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0},
    '{3'd3, 64'h4000_0000_0000_0010, 64'h20, 64'h0,
      64'hC000_0000_0000_0010, 64'h20, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0},
    '{3'd4, 64'hE000_0000_0000_0100, 64'h200, 64'h0,
      64'h100, 64'h200, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0},
    '{3'd4, 64'h3000_0000_0000_0200, 64'h300, 64'h0,
      64'hF000_0000_0000_0200, 64'h300, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0},
    '{3'd5, 64'hFFFF_FFFF_8000_0000, 64'h1111_2222_3333_4444, 64'hA000_0000_0000_0123,
      64'hFFFF_FFFF_8000_0000, 64'h1111_2222_3333_4444, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0123},
    '{3'd6, 64'h8000_7FFF_0000_0010, 64'h0ABC_8000_1234_5678, 64'h0,
      64'h0000_7FFF_0000_0010, 64'hFFFF_8000_1234_5678, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0ABC},
    '{3'd6, 64'h4000_0000_0000_0001, 64'h0005_0000_0000_0040, 64'h0,
      64'hC000_0000_0000_0001, 64'h40, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0005},
    '{3'd2, 64'hFFFF_FFFF_FFFF_FFF0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF,
      64'hFFFF_FFFF_FFFF_FFF0, 64'h1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0},
    '{3'd1, 64'hE000_0000_0000_0001, 64'hE000_0000_0000_0002, 64'hFFFF_FFFF_FFFF_FFFF,
      64'hE000_0000_0000_0001, 64'hE000_0000_0000_0002, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        fmt_i = '0;
  logic              dup_abort_en_i = 1'b0;
  logic [TAG_W-1:0]  type_mask_i = M_ALL;
  logic              rec_valid_i = 1'b0, rec_last_i = 1'b0;
  logic [63:0]       rec_src_i = '0, rec_dst_i = '0, rec_info_i = '0;
  logic [TAG_W-1:0]  rec_tag_i = '0;
  logic              rec_ready_o, ent_valid_o, ent_ready_i = 1'b0;
  logic [63:0]       ent_src_o, ent_dst_o;
  logic              ent_mispred_o, ent_pred_o, ent_in_tx_o, ent_abort_o;
  logic [15:0]       ent_cycles_o;
  logic [CNT_W-1:0]  cnt_o;
  logic              done_o;

  always #4 clk = ~clk;

  br_rec_compactor #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .fmt_i(fmt_i), .dup_abort_en_i(dup_abort_en_i),
    .type_mask_i(type_mask_i), .rec_valid_i(rec_valid_i), .rec_ready_o(rec_ready_o),
    .rec_last_i(rec_last_i), .rec_src_i(rec_src_i), .rec_dst_i(rec_dst_i),
    .rec_info_i(rec_info_i), .rec_tag_i(rec_tag_i), .ent_valid_o(ent_valid_o),
    .ent_ready_i(ent_ready_i), .ent_src_o(ent_src_o), .ent_dst_o(ent_dst_o),
    .ent_mispred_o(ent_mispred_o), .ent_pred_o(ent_pred_o), .ent_in_tx_o(ent_in_tx_o),
    .ent_abort_o(ent_abort_o), .ent_cycles_o(ent_cycles_o), .cnt_o(cnt_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [63:0] g_src [8], g_dst [8];
  logic [19:0] g_fl  [8];
  int g_n, g_cnt;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [63:0] s, logic [63:0] d, logic [63:0] inf,
                      logic [TAG_W-1:0] tg, bit last);
    @(negedge clk);
    rec_src_i = s; rec_dst_i = d; rec_info_i = inf; rec_tag_i = tg;
    rec_last_i = last; rec_valid_i = 1'b1;
    @(posedge clk);
    #1 rec_valid_i = 1'b0; rec_last_i = 1'b0;
    if (!last) begin
      @(negedge clk);
      chk("R12", "valid while filling", 64'(ent_valid_o), 64'h0);
    end
  endtask

  task automatic collect(bit throttle);
    g_n = 0; g_cnt = -1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      ent_ready_i = throttle ? c[0] : 1'b1;
      if (ent_valid_o && ent_ready_i && g_n < 8) begin
        g_src[g_n] = ent_src_o; g_dst[g_n] = ent_dst_o;
        g_fl[g_n]  = {ent_mispred_o, ent_pred_o, ent_in_tx_o, ent_abort_o, ent_cycles_o};
        g_n++;
      end
      if (done_o) begin
        g_cnt = int'(cnt_o);
        break;
      end
    end
    ent_ready_i = 1'b0;
  endtask

  function automatic string req_of(logic [2:0] f);
    case (f)
      3'd0: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ready", 64'(rec_ready_o), 64'h1);
    chk("R1", "valid", 64'(ent_valid_o), 64'h0);
    chk("R1", "done",  64'(done_o), 64'h0);
    chk("R1", "count", 64'(cnt_o), 64'h0);
    rst_ni = 1'b1;

    // layout table, one record per batch, everything kept
    for (int i = 0; i < NV; i++) begin
      fmt_i = VT[i].fmt;
      send(VT[i].src, VT[i].dst, VT[i].info, 18'h1, 1'b1);
      collect(1'b0);
      chk(req_of(VT[i].fmt), "entries", 64'(g_n), 64'h1);
      chk(req_of(VT[i].fmt), "src", g_src[0], VT[i].esrc);
      chk(req_of(VT[i].fmt), "dst", g_dst[0], VT[i].edst);
      chk(req_of(VT[i].fmt), "flags",
          64'(g_fl[0]), 64'({VT[i].emis, VT[i].epred, VT[i].etx, VT[i].eab, VT[i].ecyc}));
    end

    // R9 subset filter, R12 order, R14 throttled drain
    fmt_i = 3'd2; type_mask_i = T_UJ;
    send(64'h1, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h2, 64'h0, 64'h0, 18'h00005, 1'b0);
    send(64'h3, 64'h0, 64'h0, 18'h0, 1'b0);
    send(64'h4, 64'h0, 64'h0, T_UJ, 1'b1);
    collect(1'b1);
    chk("R9",  "kept", 64'(g_n), 64'h2);
    chk("R12", "first", g_src[0], 64'h1);
    chk("R14", "second", g_src[1], 64'h4);
    chk("R12", "count", 64'(g_cnt), 64'h2);

    // R10 full mask keeps zero tag
    type_mask_i = M_ALL;
    send(64'h7, 64'h0, 64'h0, 18'h0, 1'b0);
    send(64'h8, 64'h0, 64'h0, 18'h8, 1'b1);
    collect(1'b0);
    chk("R10", "count", 64'(g_cnt), 64'h2);
    chk("R10", "zero tag entry", g_src[0], 64'h7);

    // R11 transaction filtering
    fmt_i = 3'd4; type_mask_i = T_UJ | 18'h02000;
    send(64'h4000_0000_0000_0011, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h22, 64'h0, 64'h0, T_UJ, 1'b1);
    collect(1'b0);
    chk("R11", "in-tx count", 64'(g_cnt), 64'h1);
    chk("R11", "in-tx src", g_src[0], 64'h11);
    type_mask_i = T_UJ | 18'h04000;
    send(64'h4000_0000_0000_0011, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h22, 64'h0, 64'h0, T_UJ, 1'b1);
    collect(1'b0);
    chk("R11", "no-tx count", 64'(g_cnt), 64'h1);
    chk("R11", "no-tx src", g_src[0], 64'h22);

    // R8 duplicate abort
    type_mask_i = M_ALL; dup_abort_en_i = 1'b1;
    send(64'h1, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h2000_0000_0000_0002, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h3, 64'h0, 64'h0, T_UJ, 1'b1);
    collect(1'b0);
    chk("R8", "overwrite count", 64'(g_cnt), 64'h2);
    chk("R8", "overwrite src", g_src[0], 64'h2);
    chk("R8", "overwrite abort", 64'(g_fl[0][16]), 64'h1);
    chk("R8", "next src", g_src[1], 64'h3);
    send(64'h2000_0000_0000_0005, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h6, 64'h0, 64'h0, T_UJ, 1'b1);
    collect(1'b0);
    chk("R8", "first-abort count", 64'(g_cnt), 64'h2);
    chk("R8", "first-abort src", g_src[0], 64'h5);
    type_mask_i = T_UJ;
    send(64'h1, 64'h0, 64'h0, 18'h4, 1'b0);
    send(64'h2000_0000_0000_0002, 64'h0, 64'h0, T_UJ, 1'b1);
    collect(1'b0);
    chk("R8", "revive count", 64'(g_cnt), 64'h1);
    chk("R8", "revive src", g_src[0], 64'h2);
    send(64'h1, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h2000_0000_0000_0002, 64'h0, 64'h0, 18'h4, 1'b1);
    collect(1'b0);
    chk("R8", "erase count", 64'(g_cnt), 64'h0);
    type_mask_i = M_ALL; dup_abort_en_i = 1'b0;
    send(64'h1, 64'h0, 64'h0, T_UJ, 1'b0);
    send(64'h2000_0000_0000_0002, 64'h0, 64'h0, T_UJ, 1'b1);
    collect(1'b0);
    chk("R8", "disabled count", 64'(g_cnt), 64'h2);

    // R13 capacity
    fmt_i = 3'd2;
    for (int k = 0; k < 6; k++) send(64'(10 + k), 64'h0, 64'h0, T_UJ, k == 5);
    collect(1'b0);
    chk("R13", "count", 64'(g_cnt), 64'(DEPTH));
    chk("R13", "first", g_src[0], 64'd10);
    chk("R13", "last stored", g_src[DEPTH-1], 64'(10 + DEPTH - 1));
    @(negedge clk);
    chk("R12", "count held", 64'(cnt_o), 64'(DEPTH));

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule